// File: doc/BRIEF.md
# Randomized AES Round and Byte Scheduler

This block sequences a byte-serial AES-128 datapath so that the cycle in which real key-dependent work happens is hidden. Every encryption runs a constant 25 rounds of 16 byte slots each. Ten of the rounds are real. The other fifteen are dummy rounds that the datapath runs on random operands. A random share of the dummy rounds runs before the real rounds, and the remainder runs after them. Within every round, the sixteen state bytes are visited in a random order.

At `start`, the scheduler takes one random word. From that word it draws the leading dummy count, a start offset and an odd step for the byte walk. It also inserts a short random stall, equivalent to the initial key addition delay, before the first byte strobe. With the countermeasures switched off, the schedule is fixed: no stall, no leading dummy rounds, and bytes in ascending order.

The datapath consumes `byte_stb`, `byte_idx`, `round_idx` and `dummy`. When `dummy` is high, it selects random operands and blocks state writeback.

Top module: `aes_round_shuffler`

## Requirements
- R1: While reset is held and right after it, `byte_stb`, `dummy` and `done` are low.
- R2: A `start` seen while idle captures `rnd_in`. The leading dummy count L is `rnd_in[3:0]`. Exactly L mod 4 stall cycles with `byte_stb` low follow the capturing edge, and then the strobes begin.
- R3: One encryption gives exactly 400 consecutive byte strobes. `round_idx` is 0 for the first 16 strobes and rises by one every 16 strobes, up to 24.
- R4: Rounds with index below L, or at or above L+10, are dummy rounds. The ten rounds L to L+9 are real, so 240 strobes carry `dummy` and 160 do not.
- R5: In slot k of every round, `byte_idx` = (O + k*S) mod 16. Here O = `rnd_in[7:4]` and S = 2*`rnd_in[10:8]`+1. Each index therefore appears exactly once per round.
- R6: With `cm_en` low at start, L = 0, there are no stall cycles, and `byte_idx` equals the slot number.
- R7: `done` is high for exactly one cycle, the cycle right after the last strobe, and the block is idle again in that cycle.
- R8: A `start` or a change of `rnd_in` while an encryption is in progress has no effect on the schedule.
- R9: `dummy` is never high while `byte_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an encryption schedule when idle |
| cm_en | input | 1 | Enable stall, dummy placement and byte shuffling |
| rnd_in | input | 11 | Random word: [3:0] leading dummies, [7:4] offset, [10:8] step |
| round_idx | output | 5 | Current round slot, 0 to 24 |
| dummy | output | 1 | Current byte strobe belongs to a dummy round |
| byte_idx | output | 4 | State byte to process this cycle |
| byte_stb | output | 1 | A byte is processed this cycle |
| done | output | 1 | One-cycle pulse after the final byte |

## Verification
The bench targets the extremes of the random word.

A leading count of 15 puts all dummies in front, and a count of 0 puts them all behind. An off-by-one in the dummy window would then mark a real round as dummy, or the reverse.

A step of 15 with an offset of 15 checks the wrap in the byte walk. An adder of the wrong width would repeat or skip an index.

The stall lengths 0 to 3 check that the first strobe lands on the computed cycle.

A start pulse injected mid-run, together with a new random word, would restart or reshuffle a scheduler that fails to ignore it.

// File: rtl/aes_round_shuffler.sv
module aes_round_shuffler #(
  parameter int NBYTE  = 16,
  parameter int NREAL  = 10,
  parameter int NDUMMY = 15,
  parameter int RW     = 11
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic                                 cm_en,
  input  logic [RW-1:0]                        rnd_in,
  output logic [$clog2(NREAL+NDUMMY)-1:0]      round_idx,
  output logic                                 dummy,
  output logic [$clog2(NBYTE)-1:0]             byte_idx,
  output logic                                 byte_stb,
  output logic                                 done
);
  localparam int BW  = $clog2(NBYTE);
  localparam int NRD = NREAL + NDUMMY;
  localparam int RDW = $clog2(NRD);
  localparam int LW  = $clog2(NDUMMY + 1);
  localparam int SB  = BW - 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;

  st_t            st;
  logic [RDW-1:0] lead_q, round_q;
  logic [BW-1:0]  off_q, step_q, pos_q, slot_q;
  logic [1:0]     dly_q;
  logic           done_q;

  logic [LW-1:0]  lead_raw;
  logic [RDW-1:0] lead_n;
  logic [BW-1:0]  off_n, step_n;

  assign lead_raw = rnd_in[LW-1:0];
  assign lead_n   = !cm_en ? '0 :
                    (int'(lead_raw) > NDUMMY) ? RDW'(NDUMMY) : RDW'(lead_raw);
  assign off_n    = cm_en ? rnd_in[LW +: BW] : '0;
  assign step_n   = cm_en ? {rnd_in[LW+BW +: SB], 1'b1} : BW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lead_q  <= '0;
      round_q <= '0;
      off_q   <= '0;
      step_q  <= BW'(1);
      pos_q   <= '0;
      slot_q  <= '0;
      dly_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          lead_q  <= lead_n;
          off_q   <= off_n;
          step_q  <= step_n;
          pos_q   <= off_n;
          slot_q  <= '0;
          round_q <= '0;
          dly_q   <= lead_n[1:0];
          st      <= (lead_n[1:0] != 2'd0) ? S_WAIT : S_RUN;
        end
        S_WAIT: begin
          dly_q <= dly_q - 2'd1;
          if (dly_q == 2'd1) st <= S_RUN;
        end
        S_RUN: begin
          if (int'(slot_q) == NBYTE - 1) begin
            slot_q <= '0;
            pos_q  <= off_q;
            if (int'(round_q) == NRD - 1) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              round_q <= round_q + RDW'(1);
            end
          end else begin
            slot_q <= slot_q + BW'(1);
            pos_q  <= BW'(pos_q + step_q);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign byte_stb  = (st == S_RUN);
  assign byte_idx  = pos_q;
  assign round_idx = round_q;
  assign done      = done_q;
  assign dummy     = byte_stb &&
                     ((round_q < lead_q) || (int'(round_q) >= int'(lead_q) + NREAL));
endmodule

// File: rtl/aes_round_shuffler_chk.sv
module aes_round_shuffler_chk #(
  parameter int NBYTE = 16,
  parameter int RDW   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     byte_stb,
  input logic                     dummy,
  input logic                     done,
  input logic [$clog2(NBYTE)-1:0] byte_idx,
  input logic [RDW-1:0]           round_idx
);
  localparam int BW = $clog2(NBYTE);
  logic [NBYTE-1:0] seen;
  logic [BW-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !byte_stb) begin
      seen <= '0;
      cnt  <= '0;
    end else if (int'(cnt) == NBYTE - 1) begin
      seen <= '0;
      cnt  <= '0;
    end else begin
      seen <= seen | (NBYTE'(1) << byte_idx);
      cnt  <= cnt + BW'(1);
    end
  end

  a_r9_dummy_only_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
    dummy |-> byte_stb);
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(byte_stb) && !byte_stb));
  a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> !seen[byte_idx]);
  a_r3_round_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && $past(byte_stb)) |->
      (round_idx == $past(round_idx) || round_idx == $past(round_idx) + RDW'(1)));
  a_r3_round_starts_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_stb) |-> (round_idx == '0));
endmodule

bind aes_round_shuffler aes_round_shuffler_chk #(.NBYTE(NBYTE), .RDW(RDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .dummy(dummy), .done(done),
  .byte_idx(byte_idx), .round_idx(round_idx)
);

// File: tb/tb_aes_round_shuffler.sv
`timescale 1ns/1ps
module tb_aes_round_shuffler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cm_en = 1'b0;
  logic [10:0] rnd_in = '0;
  logic [4:0]  round_idx;
  logic        dummy;
  logic [3:0]  byte_idx;
  logic        byte_stb;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  aes_round_shuffler dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cm_en(cm_en), .rnd_in(rnd_in),
    .round_idx(round_idx), .dummy(dummy), .byte_idx(byte_idx),
    .byte_stb(byte_stb), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  function automatic int exp_byte(input logic [10:0] r, input bit en, input int k);
    int o = en ? int'(r[7:4]) : 0;
    int s = en ? 2 * int'(r[10:8]) + 1 : 1;
    return (o + k * s) % 16;
  endfunction

  task automatic run(input bit en, input logic [10:0] r, input int busy_at);
    int  lead = en ? int'(r[3:0]) : 0;
    int  d    = lead % 4;
    int  nd   = 0;
    bit  e2 = 0, e3 = 0, e4 = 0, e5 = 0, e7 = 0, e9 = 0;
    string m2 = "", m3 = "", m4 = "", m5 = "", m7 = "", m9 = "";
    logic [15:0] mask = '0;
    bit  okmask = 1;
    @(negedge clk);
    cm_en = en; rnd_in = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= d + 401; c++) begin
      bit    es = (c >= d) && (c < d + 400);
      int    t  = c - d;
      if (c == busy_at) begin start = 1'b1; rnd_in = ~r; cm_en = ~en; end
      else if (c == busy_at + 1) start = 1'b0;
      if (byte_stb !== es) begin
        if (c < d) begin e2 = 1; m2 = $sformatf("c=%0d stb=%b exp=%b", c, byte_stb, es); end
        else begin e3 = 1; m3 = $sformatf("c=%0d stb=%b exp=%b", c, byte_stb, es); end
      end
      if (es) begin
        int er = t / 16, eb = exp_byte(r, en, t % 16);
        bit ed = (er < lead) || (er >= lead + 10);
        if (round_idx !== 5'(er)) begin e3 = 1; m3 = $sformatf("c=%0d round=%0d exp=%0d", c, round_idx, er); end
        if (byte_idx !== 4'(eb)) begin e5 = 1; m5 = $sformatf("c=%0d byte=%0d exp=%0d", c, byte_idx, eb); end
        if (dummy !== ed) begin e4 = 1; m4 = $sformatf("c=%0d round=%0d dummy=%b exp=%b", c, er, dummy, ed); end
        if (dummy === 1'b1) nd++;
        if (t % 16 == 0) mask = '0;
        mask[byte_idx] = 1'b1;
        if (t % 16 == 15 && mask !== 16'hFFFF) okmask = 0;
      end else if (dummy !== 1'b0) begin
        e9 = 1; m9 = $sformatf("c=%0d dummy=%b exp=0", c, dummy);
      end
      if (done !== (c == d + 400)) begin e7 = 1; m7 = $sformatf("c=%0d done=%b exp=%b", c, done, c == d + 400); end
      @(negedge clk);
    end
    chk(!e2, "R2", m2);
    chk(!e3, busy_at >= 0 ? "R3/R8" : "R3", m3);
    chk(!e4 && nd == 240, "R4", $sformatf("%s dummy_strobes=%0d exp=240", m4, nd));
    chk(!e5 && okmask, en ? "R5" : "R6", $sformatf("%s perm_ok=%0b exp=1", m5, okmask));
    chk(!e7, "R7", m7);
    chk(!e9, "R9", m9);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(byte_stb === 1'b0 && dummy === 1'b0 && done === 1'b0, "R1",
        $sformatf("in reset stb=%b dummy=%b done=%b exp=000", byte_stb, dummy, done));
    rst_n = 1'b1;
    @(negedge clk);
    chk(byte_stb === 1'b0 && done === 1'b0, "R1",
        $sformatf("after reset stb=%b done=%b exp=00", byte_stb, done));
    run(1'b0, 11'h7FF, -1);
    run(1'b1, 11'h000, -1);
    run(1'b1, 11'h7FF, -1);
    run(1'b1, 11'h3A1, 50);
    run(1'b1, 11'h0F2, -1);
    run(1'b1, 11'h50A, 399);
    run(1'b0, 11'h123, 10);
    for (int i = 0; i < 20; i++) begin
      logic [10:0] r = 11'($urandom);
      int b = ($urandom % 3 == 0) ? int'($urandom % 390) : -1;
      run(1'b1, r, b);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule